// File: doc/BRIEF.md
# Write Strobe Stretcher

This block sits between a fast bus master and a slow write-only peripheral. The master's write strobe is often too short for the peripheral, and its data hold time after the strobe rises is too small. The block watches the qualified write strobe, meaning the write strobe and the chip select both low. It detects the falling edge of that strobe after a two-flop synchronizer. On that edge it fires a one-shot that drives the peripheral's active-low write strobe for a fixed number of clock cycles.

At the same time the block raises a wait request toward the master. The master keeps its bus cycle open, with data and address held, for as long as the wait request is high. The wait request stays high for a configurable number of cycles after the peripheral strobe has risen again. As a result, the data is valid for the whole peripheral pulse, which covers setup, and it stays valid for a guaranteed hold time after the latching edge.

Lengths are counted in clock cycles. The designer chooses `PULSE_CYCLES` and `HOLD_CYCLES` so that, at the clock period in use, they cover the peripheral's minimum pulse width and minimum hold time.

Top module: `write_strobe_stretcher`

## Requirements
- R1: The qualified strobe is low only when `sysWrN` and `csN` are both low. Suppose the qualified strobe is first sampled low at rising clock edge k, after being sampled high at edge k-1. Then `perWrN` is still high after edge k+1 and goes low after edge k+2.
- R2: Once started, `perWrN` stays low for exactly `PULSE_CYCLES` clock cycles and then returns high.
- R3: The one-shot cannot be retriggered. A falling edge of the qualified strobe is ignored if it is detected while a pulse or its hold phase is in progress (while `waitReq` is high). Such an edge neither lengthens nor restarts the pulse.
- R4: `waitReq` rises on the same clock edge on which `perWrN` falls. It then stays high for exactly `PULSE_CYCLES + HOLD_CYCLES` cycles, so it is high whenever `perWrN` is low.
- R5: `perWrN` returns high while `waitReq` is still high. `waitReq` then drops exactly `HOLD_CYCLES` cycles after `perWrN` rises.
- R6: A write strobe while `csN` is high produces no pulse and no wait request.
- R7: While `rstN` is low, `perWrN` is high and `waitReq` is low.
- R8: A qualified strobe that is low for a single clock cycle still produces a full-length pulse and a full wait window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the pulse |
| rstN | input | 1 | Asynchronous reset, active low |
| sysWrN | input | 1 | Bus master write strobe, active low, asynchronous to clk |
| csN | input | 1 | Chip select qualifying the strobe, active low |
| perWrN | output | 1 | Stretched write strobe to the peripheral, active low |
| waitReq | output | 1 | Request to the master to hold its bus cycle open, active high |

## Verification
If the state machine or the counter goes wrong inside, the fault shows at the ports within one pulse window. The low time of `perWrN` or the high time of `waitReq` becomes longer or shorter than its parameter. `perWrN` may also rise after `waitReq` has already dropped, which would lose data hold on a real bus. If the edge detector or the idle gating fails, `perWrN` falls in the middle of a wait window, or falls with no qualified edge. This is seen within three cycles of the offending input edge. The bench models the required latency and window lengths cycle by cycle. It compares both outputs on every cycle under directed and random strobe patterns.

// File: rtl/strb_pkg.sv
package strb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_HOLD  = 2'd2
  } strbState_t;

  // Strobes from the control to the datapath counter
  typedef struct packed {
    logic loadPulse;
    logic loadHold;
    logic dec;
  } strbCtrl_t;

endpackage

// File: rtl/strb_datapath.sv
module strb_datapath
  import strb_pkg::*;
#(
  parameter int PULSE_CYCLES = 12,
  parameter int HOLD_CYCLES  = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sysWrN,
  input  logic      csN,
  input  strbCtrl_t ctrl,
  output logic      fallSeen,
  output logic      cntZero
);

  localparam int MAX_LEN = (PULSE_CYCLES > HOLD_CYCLES) ? PULSE_CYCLES : HOLD_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'(HOLD_CYCLES - 1);

  logic                 qualN;
  logic [SYNC_STAGES:0] syncQ;   // synchronizer stages plus one edge-history flop
  logic [CNT_W-1:0]     cnt;

  assign qualN = sysWrN | csN;

  // Synchronizer chain; the last stage is the previous value for edge detection
  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= qualN;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign fallSeen = syncQ[SYNC_STAGES] & ~syncQ[SYNC_STAGES-1];

  // Down-counter shared by the pulse and hold phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrl.loadPulse) begin
      cnt <= PULSE_LOAD;
    end else if (ctrl.loadHold) begin
      cnt <= HOLD_LOAD;
    end else if (ctrl.dec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= PULSE_LOAD || cnt <= HOLD_LOAD);  // R2

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.loadPulse && ctrl.loadHold));  // R3

endmodule

// File: rtl/strb_control.sv
module strb_control
  import strb_pkg::*;
#(
  parameter int PULSE_CYCLES = 12,
  parameter int HOLD_CYCLES  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fallSeen,
  input  logic      cntZero,
  output strbCtrl_t ctrl,
  output logic      perWrN,
  output logic      waitReq
);

  localparam int RUN_W = $clog2(PULSE_CYCLES + 2) + 1;

  strbState_t state, stateNext;
  logic       perNext, waitNext;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    perNext   = perWrN;
    waitNext  = waitReq;
    case (state)
      ST_IDLE: begin
        if (fallSeen) begin
          ctrl.loadPulse = 1'b1;
          stateNext      = ST_PULSE;
          perNext        = 1'b0;
          waitNext       = 1'b1;
        end
      end
      ST_PULSE: begin
        if (cntZero) begin
          ctrl.loadHold = 1'b1;
          stateNext     = ST_HOLD;
          perNext       = 1'b1;
        end else begin
          ctrl.dec = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          stateNext = ST_IDLE;
          waitNext  = 1'b0;
        end else begin
          ctrl.dec = 1'b1;
        end
      end
      default: begin
        stateNext = ST_IDLE;
        perNext   = 1'b1;
        waitNext  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      perWrN  <= 1'b1;
      waitReq <= 1'b0;
    end else begin
      state   <= stateNext;
      perWrN  <= perNext;
      waitReq <= waitNext;
    end
  end

  // Length of the current low run of the peripheral strobe, for checking only
  logic [RUN_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowRun <= '0;
    else if (!perWrN) lowRun <= lowRun + 1'b1;
    else              lowRun <= '0;
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && fallSeen) |=> !perWrN);  // R1

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perWrN) |-> lowRun == RUN_W'(PULSE_CYCLES));  // R2

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(perWrN) |-> $past(state) == ST_IDLE);  // R3

  AST_WAIT_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    !perWrN |-> waitReq);  // R4

  AST_HOLD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perWrN) |-> waitReq);  // R5

endmodule

// File: rtl/write_strobe_stretcher.sv
module write_strobe_stretcher
  import strb_pkg::*;
#(
  parameter int PULSE_CYCLES = 12,
  parameter int HOLD_CYCLES  = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sysWrN,
  input  logic csN,
  output logic perWrN,
  output logic waitReq
);

  strbCtrl_t ctrl;
  logic      fallSeen;
  logic      cntZero;

  strb_datapath #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .sysWrN  (sysWrN),
    .csN     (csN),
    .ctrl    (ctrl),
    .fallSeen(fallSeen),
    .cntZero (cntZero)
  );

  strb_control #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .fallSeen(fallSeen),
    .cntZero (cntZero),
    .ctrl    (ctrl),
    .perWrN  (perWrN),
    .waitReq (waitReq)
  );

  AST_CS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (!waitReq && $past(csN) && $past(csN, 2) && $past(csN, 3)) |=> !$fell(perWrN));  // R6

endmodule

// File: tb/test_write_strobe_stretcher.sv
`timescale 1ns/1ps
module test_write_strobe_stretcher;

  localparam int P = 12;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rstN;
  logic sysWrN, csN;
  logic perWrN, waitReq;

  int checks = 0;
  int errors = 0;
  bit chkEn  = 1'b0;
  bit done   = 1'b0;
  string tagPer  = "R2";
  string tagWait = "R4";

  always #2.5 clk = ~clk;

  write_strobe_stretcher #(.PULSE_CYCLES(P), .HOLD_CYCLES(H), .SYNC_STAGES(2)) i_write_strobe_stretcher (
    .clk(clk), .rstN(rstN), .sysWrN(sysWrN), .csN(csN),
    .perWrN(perWrN), .waitReq(waitReq)
  );

  // Requirement model: qualified samples, and the cycles left in the wait window
  logic q1, q2, q3;
  int   rem;

  always @(posedge clk) begin
    if (!rstN) begin
      q1 <= 1'b1; q2 <= 1'b1; q3 <= 1'b1; rem <= 0;
    end else begin
      q1 <= sysWrN | csN;
      q2 <= q1;
      q3 <= q2;
      if (rem == 0 && q3 && !q2) rem <= P + H;
      else if (rem > 0)          rem <= rem - 1;
    end
  end

  function automatic logic expPer(int r);
    return !(r > H);
  endfunction

  function automatic logic expWait(int r);
    return (r > 0);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chkEn) begin
      chk(perWrN,  expPer(rem),  tagPer,  "perWrN");
      chk(waitReq, expWait(rem), tagWait, "waitReq");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (waitReq) @(negedge clk);
  endtask

  initial begin
    sysWrN = 1'b1; csN = 1'b1; rstN = 1'b0;
    idle(3);
    chk(perWrN, 1'b1, "R7", "perWrN in reset");
    chk(waitReq, 1'b0, "R7", "waitReq in reset");
    sysWrN = 1'b0; csN = 1'b0;
    idle(2);
    chk(perWrN, 1'b1, "R7", "perWrN in reset with strobe low");
    chk(waitReq, 1'b0, "R7", "waitReq in reset with strobe low");
    sysWrN = 1'b1; csN = 1'b1;
    idle(1);
    rstN = 1'b1;
    idle(4);
    chkEn = 1'b1;

    // R1: latency of the first low edge of perWrN
    tagPer = "R1"; tagWait = "R4";
    sysWrN = 1'b0; csN = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(perWrN, 1'b1, "R1", "perWrN after two edges");
    @(posedge clk); @(negedge clk);
    chk(perWrN, 1'b0, "R1", "perWrN after three edges");
    chk(waitReq, 1'b1, "R4", "waitReq with pulse start");
    waitIdle();
    sysWrN = 1'b1; csN = 1'b1;
    idle(5);

    // R8: single-cycle strobe is stretched to a full pulse
    tagPer = "R8"; tagWait = "R8";
    csN = 1'b0; sysWrN = 1'b0;
    idle(1);
    sysWrN = 1'b1;
    idle(P + H + 6);
    csN = 1'b1;

    // R6: strobes without chip select
    tagPer = "R6"; tagWait = "R6";
    for (int i = 0; i < 5; i++) begin
      sysWrN = 1'b0; idle(2);
      sysWrN = 1'b1; idle(2);
      chk(perWrN, 1'b1, "R6", "perWrN without select");
      chk(waitReq, 1'b0, "R6", "waitReq without select");
    end
    idle(4);

    // R3: extra edges inside the window are ignored
    tagPer = "R3"; tagWait = "R3";
    csN = 1'b0; sysWrN = 1'b0;
    idle(4);
    for (int i = 0; i < 4; i++) begin
      sysWrN = 1'b1; idle(1);
      sysWrN = 1'b0; idle(2);
    end
    sysWrN = 1'b1;
    idle(P + H + 6);

    // R5: hold gap between perWrN rising and waitReq dropping
    tagPer = "R5"; tagWait = "R5";
    sysWrN = 1'b0;
    idle(4);
    while (!perWrN == 1'b0 && waitReq == 1'b0) @(negedge clk);
    while (!perWrN) @(negedge clk);
    chk(waitReq, 1'b1, "R5", "waitReq when perWrN rises");
    begin
      int gap = 0;
      while (waitReq && gap < 100) begin
        gap++;
        @(negedge clk);
      end
      checks++;
      if (gap != H) begin
        errors++;
        $display("FAIL R5 hold gap actual %0d expected %0d", gap, H);
      end
    end
    sysWrN = 1'b1; csN = 1'b1;
    idle(5);

    // Random strobe and select traffic, R2 and R4 windows with R3 edges
    tagPer = "R2"; tagWait = "R4";
    void'($urandom(32'h5eed_0c1e));
    for (int i = 0; i < 3000; i++) begin
      sysWrN = ($urandom % 10) >= 3;
      csN    = ($urandom % 10) < 2;
      @(negedge clk);
    end
    sysWrN = 1'b1; csN = 1'b1;
    idle(P + H + 6);

    chkEn = 1'b0;
    done  = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule